// File: doc/BRIEF.md
# Serial Word Receiver with Chained Pass-Through

This block is the serial front end of a two-channel converter controller. A host drives a frame strobe (active low), a serial clock and a data line. The block samples all three with a much faster system clock and assembles 16-bit words, most significant bit first. Each finished word is handed to the command decoder as a one-cycle strobe, and the word stays on its output until the next one arrives. The top four bits are the command field. Below them sits a converter code of `RES_BITS` bits, left-aligned in bits 11 down.

Two framing modes are selected by an input from the register block.

- **Counted mode** takes exactly sixteen bits per frame and commits on the sixteenth capture edge.
- **Chained mode** shifts for as long as the strobe is low. Bits older than sixteen positions are passed on through the serial output to the next device. The word is committed when the strobe rises.

The capture edge can be either serial clock edge. The serial output always changes on the other edge. In counted mode, a pending readback request makes the next frame shift a supplied 16-bit value out on the serial output. A 2-bit drive code sets the output enable and reports whether weak drive is selected.

Top module: `serial_word_rx`

## Requirements
- R1: After reset, `word` is 0, `word_valid` is low, `sdo` is 0, and with chained mode on and drive code 00 `sdo_oe` is high and `sdo_weak` is low.
- R2: In counted mode (`chain_en`=0), the word is committed after the sixteenth capture edge while the strobe is still low. The committed word holds the sixteen bits, the first one received in bit 15.
- R3: In counted mode, capture edges after the sixteenth in the same frame change neither `word` nor the number of commits.
- R4: A strobe rise after fewer than sixteen bits in counted mode produces no commit and leaves `word` unchanged.
- R5: In chained mode (`chain_en`=1), nothing is committed while the strobe is low. On the strobe rise, the last sixteen bits received are committed, provided at least one bit arrived.
- R6: In chained mode, the serial output value seen just before capture edge k (counting from 1) is stream bit k-16. Downstream, the bits of the first 16-bit word therefore appear from the seventeenth edge on.
- R7: In chained mode, a frame whose length is not a multiple of sixteen commits its last sixteen bits.
- R8: With `rise_capture`=1, bits are captured on serial clock rising edges and the serial output changes on falling edges. With `rise_capture`=0, the edges are swapped.
- R9: In counted mode, a `rb_req` pulse arms a readback of `rb_data`. During the next frame `sdo_oe` is high and the output shows bit 15-(k-1) of that value before capture edge k. After that frame `sdo_oe` is low again.
- R10: Drive code `sdo_mode`: 00 full drive, 01 weak drive (`sdo_weak`=1), 10 open drain (`sdo_oe` high only while `sdo` is 0), 11 output disabled (`sdo_oe`=0).
- R11: `word_ctrl` equals `word[15:12]`, and `word_code` equals the `RES_BITS` bits of `word` starting at bit 11.
- R12: `word_valid` is high for exactly one cycle per commit, and `word` changes only in a cycle in which `word_valid` is high.
- R13: Serial clock edges while the strobe is high capture nothing and do not advance the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n_in | input | 1 | Frame strobe, active low, asynchronous |
| sclk_in | input | 1 | Serial clock, asynchronous |
| sdin_in | input | 1 | Serial data in, asynchronous |
| chain_en | input | 1 | 1 selects chained mode, 0 selects counted mode |
| rise_capture | input | 1 | 1 captures on serial clock rising edges, 0 on falling edges |
| sdo_mode | input | 2 | Serial output drive code |
| rb_req | input | 1 | One-cycle pulse that arms a readback |
| rb_data | input | 16 | Value to shift out on readback, sampled with `rb_req` |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial output enable |
| sdo_weak | output | 1 | High when weak drive is selected |
| word_valid | output | 1 | One-cycle commit strobe |
| word | output | 16 | Last committed word |
| word_ctrl | output | 4 | Command field of the last word |
| word_code | output | RES_BITS | Converter code field of the last word |

## Verification
The assertions assume the following about the inputs:
- `chain_en`, `rise_capture` and `sdo_mode` change only while the strobe is high.
- Each serial clock level lasts at least a few system clocks, so capture and launch events never fall in the same cycle.

The bench drives every serial edge four system clocks apart. It changes mode inputs only between frames, and it holds the strobe low for several cycles before the first clock edge and after the last one. Open-drain and commit checks are therefore taken at cycles where the synchronized inputs have settled.

// File: rtl/serial_rx_pkg.sv
// Shared constants and types for the serial word receiver.
package serial_rx_pkg;
    localparam int WORD_W = 16;
    localparam int CTRL_W = 4;
    localparam int FIELD_MSB = 11;

    typedef enum logic [1:0] {
        SDO_FULL = 2'b00,
        SDO_WEAK = 2'b01,
        SDO_OPEN = 2'b10,
        SDO_OFF  = 2'b11
    } sdo_mode_e;
endpackage

// File: rtl/sig_sync.sv
// Multi-stage synchronizer for W independent asynchronous inputs.
// Assumes each input is a slow level signal relative to clk; STAGES >= 2.
module sig_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift each lane through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= {STAGES{RST_VAL}};
        else        stage_q <= {stage_q[STAGES-2:0], din};
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/edge_det.sv
// Per-lane rise/fall pulse generator on already synchronized levels.
// Assumes din is in the clk domain; pulses last one cycle.
module edge_det #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= din;
    end

    for (genvar g = 0; g < W; g++) begin : g_lane
        assign rise[g] = din[g] & ~prev_q[g];
        assign fall[g] = ~din[g] & prev_q[g];
    end
endmodule

// File: rtl/frame_core.sv
// Frame assembly: counted and chained modes, commit strobe, chained
// pass-through bit and readback shifter. Assumes capture and launch
// events never coincide and mode inputs are steady inside a frame.
module frame_core
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_lvl,
    input  logic              frame_fall,
    input  logic              frame_rise,
    input  logic              cap_ev,
    input  logic              launch_ev,
    input  logic              bit_in,
    input  logic              chain_en,
    input  logic              rb_req,
    input  logic [WORD_W-1:0] rb_data,
    output logic [WORD_W-1:0] word,
    output logic              word_valid,
    output logic              out_bit,
    output logic              rb_busy
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg_q, rb_hold_q, rb_sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              full_q, seen_q, pend_q, pass_q;
    logic [WORD_W-1:0] shreg_nx;

    assign shreg_nx = {shreg_q[WORD_W-2:0], bit_in};

    // Frame state, shifting, commit and output launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            rb_hold_q  <= '0;
            rb_sh_q    <= '0;
            cnt_q      <= '0;
            full_q     <= 1'b0;
            seen_q     <= 1'b0;
            pend_q     <= 1'b0;
            pass_q     <= 1'b0;
            rb_busy    <= 1'b0;
            word       <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (frame_fall) begin
                shreg_q <= '0;
                cnt_q   <= '0;
                full_q  <= 1'b0;
                seen_q  <= 1'b0;
                pass_q  <= 1'b0;
                if (pend_q && !chain_en) begin
                    rb_busy <= 1'b1;
                    rb_sh_q <= rb_hold_q;
                    pend_q  <= 1'b0;
                end
            end else if (frame_rise) begin
                rb_busy <= 1'b0;
                if (chain_en && seen_q) begin
                    word       <= shreg_q;
                    word_valid <= 1'b1;
                end
            end else if (!frame_lvl) begin
                if (cap_ev && (chain_en || !full_q)) begin
                    shreg_q <= shreg_nx;
                    seen_q  <= 1'b1;
                    cnt_q   <= cnt_q + 1'b1;
                    if (!chain_en && cnt_q == LAST_IDX) begin
                        full_q     <= 1'b1;
                        word       <= shreg_nx;
                        word_valid <= 1'b1;
                    end
                end
                if (launch_ev) begin
                    pass_q  <= shreg_q[WORD_W-1];
                    rb_sh_q <= {rb_sh_q[WORD_W-2:0], 1'b0};
                end
            end
            if (rb_req) begin
                pend_q    <= 1'b1;
                rb_hold_q <= rb_data;
            end
        end
    end

    assign out_bit = rb_busy ? rb_sh_q[WORD_W-1] : pass_q;
endmodule

// File: rtl/sdo_drive.sv
// Serial output enable and drive-strength status from the drive code.
// Assumes sdo_mode is steady while a frame is in progress.
module sdo_drive
    import serial_rx_pkg::*;
(
    input  logic [1:0] sdo_mode,
    input  logic       chain_en,
    input  logic       rb_busy,
    input  logic       out_bit,
    output logic       sdo,
    output logic       sdo_oe,
    output logic       sdo_weak
);
    logic path_on;
    assign path_on = chain_en | rb_busy;

    // Decode the drive code into an enable.
    always_comb begin
        unique case (sdo_mode_e'(sdo_mode))
            SDO_FULL, SDO_WEAK: sdo_oe = path_on;
            SDO_OPEN:           sdo_oe = path_on & ~out_bit;
            default:            sdo_oe = 1'b0;
        endcase
    end

    assign sdo      = out_bit;
    assign sdo_weak = (sdo_mode == SDO_WEAK);
endmodule

// File: rtl/serial_word_rx.sv
// Top: serial word receiver with counted and chained framing.
// Assumes clk runs at least four times the serial clock rate and
// mode inputs change only while the frame strobe is high.
module serial_word_rx
    import serial_rx_pkg::*;
#(
    parameter int RES_BITS    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_n_in,
    input  logic                sclk_in,
    input  logic                sdin_in,
    input  logic                chain_en,
    input  logic                rise_capture,
    input  logic [1:0]          sdo_mode,
    input  logic                rb_req,
    input  logic [15:0]         rb_data,
    output logic                sdo,
    output logic                sdo_oe,
    output logic                sdo_weak,
    output logic                word_valid,
    output logic [15:0]         word,
    output logic [3:0]          word_ctrl,
    output logic [RES_BITS-1:0] word_code
);
    logic [2:0] lvl;
    logic [1:0] rise, fall;
    logic       sync_rise_ev, sync_fall_ev, cap_ev, launch_ev;
    logic       out_bit, rb_busy;

    sig_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({sdin_in, sclk_in, sync_n_in}), .dout(lvl)
    );

    edge_det #(.W(2), .RST_VAL(2'b01)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(lvl[1:0]), .rise(rise), .fall(fall)
    );

    assign sync_rise_ev = rise[0];
    assign sync_fall_ev = fall[0];
    assign cap_ev       = rise_capture ? rise[1] : fall[1];
    assign launch_ev    = rise_capture ? fall[1] : rise[1];

    frame_core u_core (
        .clk(clk), .rst_n(rst_n),
        .frame_lvl(lvl[0]), .frame_fall(sync_fall_ev), .frame_rise(sync_rise_ev),
        .cap_ev(cap_ev), .launch_ev(launch_ev), .bit_in(lvl[2]),
        .chain_en(chain_en), .rb_req(rb_req), .rb_data(rb_data),
        .word(word), .word_valid(word_valid), .out_bit(out_bit), .rb_busy(rb_busy)
    );

    sdo_drive u_drv (
        .sdo_mode(sdo_mode), .chain_en(chain_en), .rb_busy(rb_busy),
        .out_bit(out_bit), .sdo(sdo), .sdo_oe(sdo_oe), .sdo_weak(sdo_weak)
    );

    assign word_ctrl = word[WORD_W-1 -: CTRL_W];
    assign word_code = word[FIELD_MSB -: RES_BITS];
endmodule

// File: rtl/serial_word_rx_chk.sv
// Property checker for serial_word_rx, attached by bind below.
module serial_word_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        chain_en,
    input logic [1:0]  sdo_mode,
    input logic        sdo,
    input logic        sdo_oe,
    input logic        word_valid,
    input logic [15:0] word,
    input logic        rb_busy,
    input logic        sync_rise_ev
);
    p_valid_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    p_word_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word));

    p_chain_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_en && word_valid) |-> $past(sync_rise_ev));

    p_sdo_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_mode == 2'b11) |-> !sdo_oe);

    p_open_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_mode == 2'b10 && sdo_oe) |-> !sdo);

    p_oe_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && !chain_en) |-> rb_busy);
endmodule

bind serial_word_rx serial_word_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .chain_en(chain_en), .sdo_mode(sdo_mode),
    .sdo(sdo), .sdo_oe(sdo_oe), .word_valid(word_valid), .word(word),
    .rb_busy(rb_busy), .sync_rise_ev(sync_rise_ev)
);

// File: tb/serial_word_rx_bench.sv
// Directed bench for serial_word_rx: one task per scenario.
module serial_word_rx_bench;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sync_n_in, sclk_in, sdin_in, chain_en, rise_capture, rb_req;
    logic [1:0]  sdo_mode;
    logic [15:0] rb_data;
    logic        sdo, sdo_oe, sdo_weak, word_valid;
    logic [15:0] word;
    logic [3:0]  word_ctrl;
    logic [11:0] word_code;

    int          nvec = 0;
    int          nmis = 0;
    int          ncommit = 0;
    logic [15:0] last_word = '0;
    logic [63:0] sdo_cap, oe_cap;
    bit          finished = 0;

    always #2 clk = ~clk;

    serial_word_rx u_serial_word_rx (
        .clk(clk), .rst_n(rst_n), .sync_n_in(sync_n_in), .sclk_in(sclk_in),
        .sdin_in(sdin_in), .chain_en(chain_en), .rise_capture(rise_capture),
        .sdo_mode(sdo_mode), .rb_req(rb_req), .rb_data(rb_data), .sdo(sdo),
        .sdo_oe(sdo_oe), .sdo_weak(sdo_weak), .word_valid(word_valid),
        .word(word), .word_ctrl(word_ctrl), .word_code(word_code)
    );

    // Count commit strobes, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            ncommit++;
            last_word = word;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nmis++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one frame of nbits, MSB first, recording sdo/oe before each capture.
    task automatic run_frame(input logic [63:0] bits, input int nbits);
        logic idle;
        idle = ~rise_capture;
        sync_n_in = 1'b0;
        tick(6);
        for (int i = 0; i < nbits; i++) begin
            sdin_in = bits[nbits-1-i];
            tick(H);
            sdo_cap[i] = sdo;
            oe_cap[i]  = sdo_oe;
            sclk_in = ~idle;
            tick(H);
            sclk_in = idle;
        end
        tick(H + 2);
    endtask

    task automatic end_frame();
        sync_n_in = 1'b1;
        tick(8);
    endtask

    task automatic t_reset();
        check("R1 word", word, 16'h0);
        check("R1 valid", ncommit, 0);
        check("R1 sdo", sdo, 1'b0);
        check("R1 oe", sdo_oe, 1'b1);
        check("R1 weak", sdo_weak, 1'b0);
    endtask

    task automatic t_chain_two_words();
        int n0;
        logic [15:0] got;
        n0 = ncommit;
        run_frame({32'h0, 16'h9C35, 16'h4E71}, 32);
        check("R5 no commit while low", ncommit, n0);
        end_frame();
        check("R5 commit count", ncommit, n0 + 1);
        check("R5 word", word, 16'h4E71);
        for (int i = 16; i < 32; i++) got[31-i] = sdo_cap[i];
        check("R6 ripple word", got, 16'h9C35);
    endtask

    task automatic t_chain_odd();
        int n0;
        n0 = ncommit;
        run_frame(64'hABCDE, 20);
        end_frame();
        check("R7 commits", ncommit, n0 + 1);
        check("R7 last 16", word, 16'hBCDE);
    endtask

    task automatic t_counted();
        int n0;
        chain_en = 1'b0;
        tick(4);
        n0 = ncommit;
        run_frame(64'h5A3C, 16);
        check("R2 commit before rise", ncommit, n0 + 1);
        check("R2 word", word, 16'h5A3C);
        end_frame();
        check("R2 single commit", ncommit, n0 + 1);
        check("R11 ctrl", word_ctrl, 4'h5);
        check("R11 code", word_code, 12'hA3C);
        check("R9 oe idle counted", sdo_oe, 1'b0);
    endtask

    task automatic t_counted_extra();
        int n0;
        n0 = ncommit;
        run_frame(64'h12345, 20);
        end_frame();
        check("R3 commits", ncommit, n0 + 1);
        check("R3 word", word, 16'h1234);
    endtask

    task automatic t_abort();
        int n0;
        n0 = ncommit;
        run_frame(64'h3FF, 10);
        end_frame();
        check("R4 no commit", ncommit, n0);
        check("R4 word kept", word, 16'h1234);
    endtask

    task automatic t_gated();
        int n0;
        n0 = ncommit;
        sdin_in = 1'b1;
        for (int i = 0; i < 20; i++) begin
            sclk_in = 1'b0; tick(H);
            sclk_in = 1'b1; tick(H);
        end
        check("R13 no commit while high", ncommit, n0);
        run_frame(64'h0F0F, 16);
        end_frame();
        check("R13 clean frame", word, 16'h0F0F);
        check("R13 commits", ncommit, n0 + 1);
    endtask

    task automatic t_rising();
        logic [15:0] got;
        rise_capture = 1'b1;
        sclk_in = 1'b0;
        tick(6);
        run_frame(64'hC3A1, 16);
        end_frame();
        check("R8 counted rising", word, 16'hC3A1);
        chain_en = 1'b1;
        tick(4);
        run_frame({32'h0, 16'h7E18, 16'h2B64}, 32);
        end_frame();
        check("R8 chained rising word", word, 16'h2B64);
        for (int i = 16; i < 32; i++) got[31-i] = sdo_cap[i];
        check("R8 ripple opposite edge", got, 16'h7E18);
        rise_capture = 1'b0;
        sclk_in = 1'b1;
        tick(6);
    endtask

    task automatic t_readback();
        logic [15:0] got;
        logic        all_oe;
        chain_en = 1'b0;
        rb_data  = 16'hA5C3;
        rb_req   = 1'b1;
        tick(1);
        rb_req   = 1'b0;
        tick(2);
        check("R9 oe before frame", sdo_oe, 1'b0);
        run_frame(64'h0, 16);
        all_oe = 1'b1;
        for (int i = 0; i < 16; i++) begin
            got[15-i] = sdo_cap[i];
            all_oe    = all_oe & oe_cap[i];
        end
        check("R9 data out", got, 16'hA5C3);
        check("R9 oe during", all_oe, 1'b1);
        end_frame();
        check("R9 oe after", sdo_oe, 1'b0);
        run_frame(64'h0, 16);
        end_frame();
        check("R9 second frame quiet", |oe_cap[15:0], 1'b0);
    endtask

    task automatic t_drive_modes();
        logic ok;
        chain_en = 1'b1;
        sdo_mode = 2'b11;
        tick(2);
        check("R10 off", sdo_oe, 1'b0);
        sdo_mode = 2'b01;
        tick(2);
        check("R10 weak flag", sdo_weak, 1'b1);
        check("R10 weak oe", sdo_oe, 1'b1);
        sdo_mode = 2'b10;
        tick(2);
        run_frame({32'h0, 16'hB2D4, 16'h0000}, 32);
        end_frame();
        ok = 1'b1;
        for (int i = 0; i < 32; i++) ok = ok & (oe_cap[i] == ~sdo_cap[i]);
        check("R10 open drain", ok, 1'b1);
        sdo_mode = 2'b00;
        tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nmis++;
            $display("FAIL R12 watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sync_n_in = 1'b1; sclk_in = 1'b1; sdin_in = 1'b0;
        chain_en = 1'b1; rise_capture = 1'b0; sdo_mode = 2'b00;
        rb_req = 1'b0; rb_data = '0;
        tick(5);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_chain_two_words();
        t_chain_odd();
        t_counted();
        t_counted_extra();
        t_abort();
        t_gated();
        t_rising();
        t_readback();
        t_drive_modes();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end
endmodule